// File: doc/BRIEF.md
# Register-Mapped General-Purpose Pin Port

A parameterised general-purpose I/O port seen by a host as a small bank of registers. The host drives pins through an output latch and chooses per pin whether the block drives the pad. It can change the latch as a whole, or change single bits in one write through write-one set and clear registers, so no read-modify-write is needed. The direction word can be changed the same ways. Pin inputs pass through a two-flop synchroniser before they can be read back.

Build-time parameters set several things. The port width (8, 16, 32 or 64 pins, one pin per register bit) is one. The direction convention is another: no direction register, a 1 meaning drive, or a 1 meaning receive. A set-only variant drops the clear register and makes the set register the full output word. Pin numbering inside a register word can be mirrored. Bus data can be byte-swapped for hosts of the opposite byte order at 16 and 32 bits; a 64-bit port with byte swapping is rejected at elaboration. Writes use a one-hot-or-more strobe vector, so several registers can be written in one cycle from one data word. Reads are combinational from a read address.

Top module: `gpio_mmio_port`

## Requirements
- R1: While reset is held and after it is released, the output latch is zero and no pin is driven (pad_oe all zero, or all one when no direction register exists). The direction word reads as all-receive: zeros with a 1-means-drive convention, ones with a 1-means-receive convention. Writes take effect from the third rising edge after rst_n rises.
- R2: A write with wr_sel bit 0 (data) replaces the whole output latch. A cycle with no data, set or clear strobe leaves pad_out unchanged. Reading address 0 returns the pin inputs as they stood two rising edges earlier.
- R3: With wr_sel bit 1 (set), pad_out becomes the old latch OR the mask. With wr_sel bit 2 (clear), pad_out becomes the old latch AND NOT the mask. Mask bits at 0 change nothing. Address 1 reads the latch, and address 2 reads zero.
- R4: When data and set or clear strobes share a cycle, the data value is loaded first, then set, then clear. For example, data with clear of the same word gives zero.
- R5: In set-only mode a set write loads the full latch, the clear strobe has no effect, and address 1 reads back the latch.
- R6: With the 1-means-drive convention, wr_sel bit 3 loads the direction word, and pad_oe equals that word from the next cycle.
- R7: With the 1-means-receive convention, pad_oe is the inverse of the direction word.
- R8: With no direction register, pad_oe is all ones, direction strobes have no effect and address 3 reads zero.
- R9: wr_sel bit 4 sets and bit 5 clears direction bits by mask. Addresses 4 and 5 read zero.
- R10: With mirrored numbering, pin n corresponds to register bit WIDTH-1-n, for writes and reads alike.
- R11: With byte swapping, bus byte k corresponds to register byte WIDTH/8-1-k, for writes and reads alike.
- R12: Reading address 0 returns the synchronised pin input even for pins being driven, not the latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_sel | input | 6 | Write strobes: 0 data, 1 set, 2 clear, 3 direction, 4 direction set, 5 direction clear |
| wdata | input | WIDTH | Write data in bus order |
| raddr | input | 3 | Read address (0 pins, 1 latch, 2 zero, 3 direction, others zero) |
| rdata | output | WIDTH | Read data in bus order, combinational |
| pad_in | input | WIDTH | Pin inputs, pin n on bit n |
| pad_out | output | WIDTH | Output latch, pin n on bit n |
| pad_oe | output | WIDTH | Drive enable per pin |

## Verification
A corrupted latch bit shows on pad_out on the cycle after the write that caused it, and on address 1 at the same time. A wrong direction bit shows on pad_oe just as quickly, so state errors cannot hide behind later writes. Lane errors (mirroring, swapping) appear as a bit moved to the wrong pin. They are caught by single-bit and byte-marked words written and read back. Synchroniser depth errors show as address-0 data arriving one cycle early or late after a change on pad_in.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

  typedef enum logic [1:0] {
    DIR_NONE     = 2'd0,
    DIR_OUT_HIGH = 2'd1,
    DIR_IN_HIGH  = 2'd2
  } dir_mode_e;

  localparam int SEL_W = 6;

  localparam logic [SEL_W-1:0] WS_DATA = 6'b000001;
  localparam logic [SEL_W-1:0] WS_OSET = 6'b000010;
  localparam logic [SEL_W-1:0] WS_OCLR = 6'b000100;
  localparam logic [SEL_W-1:0] WS_DIR  = 6'b001000;
  localparam logic [SEL_W-1:0] WS_DSET = 6'b010000;
  localparam logic [SEL_W-1:0] WS_DCLR = 6'b100000;

  localparam logic [2:0] RA_PINS = 3'd0;
  localparam logic [2:0] RA_OUT  = 3'd1;
  localparam logic [2:0] RA_DIR  = 3'd3;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_ok_n = stage2_q;
endmodule

// File: rtl/gpio_lane_map.sv
module gpio_lane_map #(
  parameter int WIDTH     = 32,
  parameter bit BIT_REV   = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] pin_out,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] bus_out
);
  localparam int NBYTES = WIDTH / 8;

  logic [WIDTH-1:0] bus_swapped;
  logic [WIDTH-1:0] pin_regorder;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    // register bit i sits on this bus bit (byte swap is its own inverse)
    localparam int SWI = BYTE_SWAP ? ((NBYTES - 1 - i / 8) * 8 + i % 8) : i;
    // register bit feeding pin i (mirror is its own inverse)
    localparam int RVI = BIT_REV ? (WIDTH - 1 - i) : i;
    assign bus_swapped[i]  = bus_in[SWI];
    assign pin_out[i]      = bus_swapped[RVI];
    assign pin_regorder[i] = pin_in[RVI];
    assign bus_out[i]      = pin_regorder[SWI];
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_ok_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  assign pin_sync = sync_q;
endmodule

// File: rtl/gpio_latch_ctrl.sv
module gpio_latch_ctrl
  import gpio_mmio_pkg::*;
#(
  parameter int        WIDTH    = 32,
  parameter dir_mode_e DIR_MODE = DIR_OUT_HIGH,
  parameter bit        SET_ONLY = 1'b0
) (
  input  logic             clk,
  input  logic             rst_ok_n,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [WIDTH-1:0] wr_pins,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] oe
);
  localparam logic [WIDTH-1:0] DIR_RST = (DIR_MODE == DIR_IN_HIGH) ? '1 : '0;
  localparam bit HAS_DIR = (DIR_MODE != DIR_NONE);

  logic             wr_data, wr_oset, wr_oclr, wr_dir, wr_dset, wr_dclr;
  logic [WIDTH-1:0] latch_d, dir_d;
  logic             latch_en, dir_en;

  assign wr_data = |(wr_sel & WS_DATA);
  assign wr_oset = |(wr_sel & WS_OSET);
  assign wr_oclr = |(wr_sel & WS_OCLR);
  assign wr_dir  = |(wr_sel & WS_DIR);
  assign wr_dset = |(wr_sel & WS_DSET);
  assign wr_dclr = |(wr_sel & WS_DCLR);

  // output latch: data load first, then set, then clear
  always_comb begin
    latch_d = latch_q;
    if (wr_data) latch_d = wr_pins;
    if (SET_ONLY) begin
      if (wr_oset) latch_d = wr_pins;
    end else begin
      if (wr_oset) latch_d = latch_d | wr_pins;
      if (wr_oclr) latch_d = latch_d & ~wr_pins;
    end
  end

  assign latch_en = wr_data | wr_oset | (wr_oclr & !SET_ONLY);

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n)     latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end

  // direction word: load, then set, then clear
  always_comb begin
    dir_d = dir_q;
    if (wr_dir)  dir_d = wr_pins;
    if (wr_dset) dir_d = dir_d | wr_pins;
    if (wr_dclr) dir_d = dir_d & ~wr_pins;
  end

  assign dir_en = HAS_DIR & (wr_dir | wr_dset | wr_dclr);

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n)   dir_q <= DIR_RST;
    else if (dir_en) dir_q <= dir_d;
  end

  if (DIR_MODE == DIR_OUT_HIGH) begin : g_oe_direct
    assign oe = dir_q;
  end else if (DIR_MODE == DIR_IN_HIGH) begin : g_oe_invert
    assign oe = ~dir_q;
  end else begin : g_oe_always
    assign oe = '1;
  end
endmodule

// File: rtl/gpio_mmio_port.sv
module gpio_mmio_port
  import gpio_mmio_pkg::*;
#(
  parameter int        WIDTH     = 32,
  parameter dir_mode_e DIR_MODE  = DIR_OUT_HIGH,
  parameter bit        SET_ONLY  = 1'b0,
  parameter bit        BIT_REV   = 1'b0,
  parameter bit        BYTE_SWAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       wr_sel,
  input  logic [WIDTH-1:0] wdata,
  input  logic [2:0]       raddr,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  if (WIDTH != 8 && WIDTH != 16 && WIDTH != 32 && WIDTH != 64) begin : g_bad_width
    $error("gpio_mmio_port: WIDTH must be 8, 16, 32 or 64");
  end
  if (BYTE_SWAP && WIDTH == 64) begin : g_bad_swap
    $error("gpio_mmio_port: byte swapping is not available at 64 bits");
  end

  logic             rst_ok_n;
  logic [WIDTH-1:0] wr_pins;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] rd_pins;

  gpio_rst_sync u_rst_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ok_n (rst_ok_n)
  );

  gpio_lane_map #(
    .WIDTH     (WIDTH),
    .BIT_REV   (BIT_REV),
    .BYTE_SWAP (BYTE_SWAP)
  ) u_lane_map (
    .bus_in  (wdata),
    .pin_out (wr_pins),
    .pin_in  (rd_pins),
    .bus_out (rdata)
  );

  gpio_in_sync #(
    .WIDTH (WIDTH)
  ) u_in_sync (
    .clk      (clk),
    .rst_ok_n (rst_ok_n),
    .pad_in   (pad_in),
    .pin_sync (pin_sync)
  );

  gpio_latch_ctrl #(
    .WIDTH    (WIDTH),
    .DIR_MODE (DIR_MODE),
    .SET_ONLY (SET_ONLY)
  ) u_latch_ctrl (
    .clk      (clk),
    .rst_ok_n (rst_ok_n),
    .wr_sel   (wr_sel),
    .wr_pins  (wr_pins),
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .oe       (pad_oe)
  );

  // read mux in pin order; the lane map turns it into bus order
  always_comb begin
    case (raddr)
      RA_PINS: rd_pins = pin_sync;
      RA_OUT:  rd_pins = latch_q;
      RA_DIR:  rd_pins = (DIR_MODE == DIR_NONE) ? '0 : dir_q;
      default: rd_pins = '0;
    endcase
  end

  assign pad_out = latch_q;
endmodule

// File: rtl/gpio_mmio_port_chk.sv
module gpio_mmio_port_chk
  import gpio_mmio_pkg::*;
#(
  parameter int        WIDTH    = 32,
  parameter dir_mode_e DIR_MODE = DIR_OUT_HIGH,
  parameter bit        SET_ONLY = 1'b0
) (
  input logic             clk,
  input logic             rst_ok_n,
  input logic [5:0]       wr_sel,
  input logic [WIDTH-1:0] wr_pins,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe
);
  localparam logic [WIDTH-1:0] OE_RST = (DIR_MODE == DIR_NONE) ? '1 : '0;
  localparam logic [5:0] OUT_SEL = WS_DATA | WS_OSET | WS_OCLR;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_ok_n |=> (pad_out == '0) && (pad_oe == OE_RST));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((wr_sel & OUT_SEL) == '0) |=> $stable(pad_out));

  if (!SET_ONLY) begin : g_setclr
    p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (wr_sel == WS_OSET) |=> pad_out == ($past(pad_out) | $past(wr_pins)));
    p_clr_andn_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (wr_sel == WS_OCLR) |=> pad_out == ($past(pad_out) & ~$past(wr_pins)));
    p_data_then_clr_r4: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (wr_sel == (WS_DATA | WS_OCLR)) |=> pad_out == '0);
  end else begin : g_setonly
    p_set_loads_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
      ((wr_sel & WS_OSET) != '0) |=> pad_out == $past(wr_pins));
  end

  if (DIR_MODE == DIR_OUT_HIGH) begin : g_dir_hi
    p_dir_drive_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (wr_sel == WS_DIR) |=> pad_oe == $past(wr_pins));
  end else if (DIR_MODE == DIR_IN_HIGH) begin : g_dir_lo
    p_dir_recv_r7: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (wr_sel == WS_DIR) |=> pad_oe == ~$past(wr_pins));
  end
endmodule

bind gpio_mmio_port gpio_mmio_port_chk #(
  .WIDTH    (WIDTH),
  .DIR_MODE (DIR_MODE),
  .SET_ONLY (SET_ONLY)
) u_chk (
  .clk      (clk),
  .rst_ok_n (rst_ok_n),
  .wr_sel   (wr_sel),
  .wr_pins  (wr_pins),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe)
);

// File: tb/gpio_mmio_port_bench.sv
module gpio_mmio_port_bench;
  import gpio_mmio_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [5:0]  wr_sel = '0;
  logic [63:0] wdata = '0;
  logic [2:0]  raddr = '0;
  logic [63:0] pad_in = '0;

  logic [31:0] rd0, po0, oe0, rd1, po1, oe1;
  logic [15:0] rd2, po2, oe2;

  // 0: 32b, 1 drives, plain lanes
  gpio_mmio_port #(.WIDTH(32), .DIR_MODE(DIR_OUT_HIGH), .SET_ONLY(1'b0),
                   .BIT_REV(1'b0), .BYTE_SWAP(1'b0)) u_gpio_mmio_port (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(wdata[31:0]), .raddr(raddr),
    .rdata(rd0), .pad_in(pad_in[31:0]), .pad_out(po0), .pad_oe(oe0));
  // 1: 32b, 1 receives, set-only, mirrored and swapped
  gpio_mmio_port #(.WIDTH(32), .DIR_MODE(DIR_IN_HIGH), .SET_ONLY(1'b1),
                   .BIT_REV(1'b1), .BYTE_SWAP(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(wdata[31:0]), .raddr(raddr),
    .rdata(rd1), .pad_in(pad_in[31:0]), .pad_out(po1), .pad_oe(oe1));
  // 2: 16b, no direction register, swapped
  gpio_mmio_port #(.WIDTH(16), .DIR_MODE(DIR_NONE), .SET_ONLY(1'b0),
                   .BIT_REV(1'b0), .BYTE_SWAP(1'b1)) u_narrow (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(wdata[15:0]), .raddr(raddr),
    .rdata(rd2), .pad_in(pad_in[15:0]), .pad_out(po2), .pad_oe(oe2));

  int cfg_w    [3] = '{32, 32, 16};
  int cfg_mode [3] = '{1, 2, 0};
  bit cfg_rev  [3] = '{1'b0, 1'b1, 1'b0};
  bit cfg_swp  [3] = '{1'b0, 1'b1, 1'b1};
  bit cfg_so   [3] = '{1'b0, 1'b1, 1'b0};

  logic [63:0] m_lat [3];
  logic [63:0] m_dir [3];
  logic [63:0] m_s1  [3];
  logic [63:0] m_s2  [3];
  int ok_cnt = 0;
  int n_cmp = 0;
  int n_bad = 0;

  function automatic logic [63:0] msk(int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] swp(logic [63:0] v, int k);
    logic [63:0] r = '0;
    int w = cfg_w[k];
    if (!cfg_swp[k]) return v;
    for (int i = 0; i < w; i++) r[i] = v[(w/8 - 1 - i/8)*8 + i%8];
    return r;
  endfunction

  function automatic logic [63:0] to_pin(logic [63:0] v, int k);
    logic [63:0] s = swp(v & msk(cfg_w[k]), k);
    logic [63:0] p = '0;
    for (int n = 0; n < cfg_w[k]; n++) p[n] = cfg_rev[k] ? s[cfg_w[k]-1-n] : s[n];
    return p;
  endfunction

  function automatic logic [63:0] to_bus(logic [63:0] p, int k);
    logic [63:0] s = '0;
    for (int b = 0; b < cfg_w[k]; b++) s[b] = cfg_rev[k] ? p[cfg_w[k]-1-b] : p[b];
    return swp(s, k);
  endfunction

  task automatic model_edge();
    for (int k = 0; k < 3; k++) begin
      logic [63:0] mk = msk(cfg_w[k]);
      logic [63:0] p = to_pin(wdata, k);
      if (!rst_n) begin
        m_lat[k] = '0;
        m_dir[k] = (cfg_mode[k] == 2) ? mk : '0;
        m_s1[k] = '0;
        m_s2[k] = '0;
      end else if (ok_cnt >= 2) begin
        m_s2[k] = m_s1[k];
        m_s1[k] = pad_in & mk;
        if (wr_sel[0]) m_lat[k] = p;
        if (cfg_so[k]) begin
          if (wr_sel[1]) m_lat[k] = p;
        end else begin
          if (wr_sel[1]) m_lat[k] = m_lat[k] | p;
          if (wr_sel[2]) m_lat[k] = m_lat[k] & ~p;
        end
        if (cfg_mode[k] != 0) begin
          if (wr_sel[3]) m_dir[k] = p;
          if (wr_sel[4]) m_dir[k] = m_dir[k] | p;
          if (wr_sel[5]) m_dir[k] = m_dir[k] & ~p;
        end
      end
    end
    if (!rst_n) ok_cnt = 0;
    else if (ok_cnt < 2) ok_cnt++;
  endtask

  task automatic cmp(string tag, string what, int k, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s inst%0d %s: actual %h expected %h", tag, k, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    for (int k = 0; k < 3; k++) begin
      logic [63:0] mk = msk(cfg_w[k]);
      logic [63:0] e_oe, e_rd, a_rd, a_po, a_oe;
      e_oe = (cfg_mode[k] == 0) ? mk : (cfg_mode[k] == 1) ? m_dir[k] : (~m_dir[k] & mk);
      case (raddr)
        3'd0: e_rd = to_bus(m_s2[k], k);
        3'd1: e_rd = to_bus(m_lat[k], k);
        3'd3: e_rd = (cfg_mode[k] == 0) ? '0 : to_bus(m_dir[k], k);
        default: e_rd = '0;
      endcase
      case (k)
        0: begin a_rd = 64'(rd0); a_po = 64'(po0); a_oe = 64'(oe0); end
        1: begin a_rd = 64'(rd1); a_po = 64'(po1); a_oe = 64'(oe1); end
        default: begin a_rd = 64'(rd2); a_po = 64'(po2); a_oe = 64'(oe2); end
      endcase
      cmp(tag, "pad_out", k, a_po, m_lat[k]);
      cmp(tag, "pad_oe", k, a_oe, e_oe);
      cmp(tag, "rdata", k, a_rd, e_rd);
    end
  endtask

  task automatic cyc(logic [5:0] sel, logic [63:0] wd, logic [2:0] ra,
                     logic [63:0] pin, string tag);
    wr_sel = sel;
    wdata  = wd;
    raddr  = ra;
    pad_in = pin;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state, direction reads all-receive
    for (int i = 0; i < 3; i++) cyc(6'h3F, 64'hFFFF_FFFF, 3'd3, 64'h0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++) cyc(6'h3F, 64'hFFFF_FFFF, 3'd1, 64'h0, "R1");
    cyc(6'h00, 64'h0, 3'd3, 64'h0, "R1");
    // R2: whole-word data load and hold
    cyc(6'h01, 64'hA5C3_0F81, 3'd1, 64'h0, "R2");
    cyc(6'h00, 64'h0, 3'd1, 64'h0, "R2");
    // R12 / R2: pin read-back through two flops, not the latch
    cyc(6'h00, 64'h0, 3'd0, 64'h1234_9ABC, "R12");
    cyc(6'h00, 64'h0, 3'd0, 64'h1234_9ABC, "R12");
    cyc(6'h00, 64'h0, 3'd0, 64'h1234_9ABC, "R2");
    cyc(6'h00, 64'h0, 3'd0, 64'hFEDC_0001, "R2");
    cyc(6'h00, 64'h0, 3'd0, 64'hFEDC_0001, "R2");
    cyc(6'h00, 64'h0, 3'd0, 64'hFEDC_0001, "R2");
    // R3: set and clear masks, zero mask, clear register reads zero
    cyc(6'h02, 64'h0000_F000, 3'd1, 64'h0, "R3");
    cyc(6'h04, 64'h0000_0081, 3'd1, 64'h0, "R3");
    cyc(6'h04, 64'h0, 3'd2, 64'h0, "R3");
    cyc(6'h02, 64'h0, 3'd1, 64'h0, "R3");
    cyc(6'h06, 64'h00F0_00F0, 3'd1, 64'h0, "R3");
    // R5: set-only variant loads and ignores clear
    cyc(6'h02, 64'h00FF_00FF, 3'd1, 64'h0, "R5");
    cyc(6'h04, 64'hFFFF_FFFF, 3'd1, 64'h0, "R5");
    // R4: same-cycle data with clear / set
    cyc(6'h05, 64'h5A5A_5A5A, 3'd1, 64'h0, "R4");
    cyc(6'h03, 64'h0F0F_0000, 3'd1, 64'h0, "R4");
    // R6 / R7 / R8: direction word
    cyc(6'h08, 64'h0000_FF0F, 3'd3, 64'h0, "R6");
    cyc(6'h00, 64'h0, 3'd3, 64'h0, "R7");
    cyc(6'h08, 64'hFFFF_FFFF, 3'd3, 64'h0, "R8");
    // R9: direction set/clear
    cyc(6'h20, 64'h00F0_00FF, 3'd3, 64'h0, "R9");
    cyc(6'h10, 64'h0000_000F, 3'd3, 64'h0, "R9");
    cyc(6'h10, 64'h0, 3'd4, 64'h0, "R9");
    cyc(6'h00, 64'h0, 3'd5, 64'h0, "R9");
    // R10: single-bit words show pin mirroring
    cyc(6'h01, 64'h0000_0001, 3'd1, 64'h0000_0001, "R10");
    cyc(6'h01, 64'h8000_0000, 3'd1, 64'h8000_0000, "R10");
    cyc(6'h00, 64'h0, 3'd0, 64'h8000_0000, "R10");
    // R11: byte-marked words show byte swapping
    cyc(6'h01, 64'h0403_0201, 3'd1, 64'h0000_0102, "R11");
    cyc(6'h00, 64'h0, 3'd0, 64'h0000_0102, "R11");
    cyc(6'h00, 64'h0, 3'd0, 64'h0000_0102, "R11");
    // mixed traffic
    for (int i = 0; i < 80; i++)
      cyc(6'($urandom), {32'h0, 32'($urandom)}, 3'($urandom), {32'h0, 32'($urandom)}, "R3");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule